// File: doc/BRIEF.md
# Boot Firmware Window Decoder

This block sits on the processor memory path and sorts every 32-bit cycle address into one of three outcomes. The cycle may be claimed by the boot firmware device, or sent to the PCI bus in its place, or left unclaimed by the firmware path. Near the top of the 4 GB space there are eight firmware windows. Each window has an alias that sits 4 MB lower (address bit 22 ignored). A 16-bit enable register gates seven of these window pairs. The highest pair is always claimed.

Two further controls change the routing. The first is a 2-bit destination field: one code sends every firmware-window hit to PCI, whatever the enables say. The second is a top-swap bit. When it is set, the block inverts address bit 16 on the address it forwards for firmware cycles. This exchanges the two highest 64 KB blocks, so the boot block can be rewritten while a known-good copy stays bootable. The registers have two resets. The battery-domain reset clears everything. The platform reset reloads the enables and the destination but leaves the swap bit alone.

Decode is purely combinational from the address and the current register state. It has no handshake and no back-pressure: the target and the forwarded address are valid in the same cycle the address is presented. Configuration goes through a one-cycle write strobe, and the registered values are driven back out on plain readback pins.

Top module: `bootwin_decoder`

## Requirements
- R1: With address bits 31:24 equal to 0xFF, bit 23 clear, and bits 21:20 equal to n (0..3), the address lies in lower window n. Bit 22 is ignored, so each window has two aliases (for example 0xFF40_0000 and 0xFF00_0000 for n=0). The target is firmware (code 2'b01) when enable bit n is set.
- R2: With bits 31:24 equal to 0xFF, bit 23 set, bit 21 set and bits 20:19 equal to m (0..2), the address lies in an upper window. The target is firmware when enable bit 12+m is set. Both aliases count (for example 0xFFE0_0000 and 0xFFA0_0000 for m=0).
- R3: Addresses 0xFFF8_0000–0xFFFF_FFFF and 0xFFB8_0000–0xFFBF_FFFF are claimed even when every enable bit is clear.
- R4: An address whose window enable bit is clear, or that lies outside every window, gives the no-claim target (code 2'b00). The forwarded address then equals the input, and code 2'b11 never appears.
- R5: When the destination field is 2'b10, every window hit goes to PCI (code 2'b10), whether its enable bit is set or clear. Addresses outside the windows stay unclaimed. Destination codes 2'b00, 2'b01 and 2'b11 route to firmware.
- R6: When the swap bit is 1, the forwarded address has bit 16 inverted on firmware-target cycles only. On PCI and no-claim cycles it passes through unchanged. When the swap bit is 0, every address passes through.
- R7: The battery-domain reset (rst_batt_n low) clears the swap bit. A platform reset (rst_plat_n low) leaves the swap bit unchanged.
- R8: Either reset loads the enable register with EN_RST_VAL and the destination field with DEST_RST_VAL. Readback shows these values right away, and the swap bit reads 0 after a battery reset.
- R9: Enable bits 4–11 and 15 read back as written and do not affect the decode.
- R10: A write with cfg_wr_i high loads a register on the next clock edge. Select code 0 loads the enables from cfg_wdata_i[15:0], code 1 loads the destination from cfg_wdata_i[1:0], and code 2 loads the swap bit from cfg_wdata_i[0]. Select code 3 changes nothing. The decode keeps using the old value until that edge.
- R11: The target and the forwarded address follow a change of addr_i within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_batt_n | input | 1 | Battery-domain reset, active low, asynchronous |
| rst_plat_n | input | 1 | Platform reset, active low, asynchronous |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select: 0 enables, 1 destination, 2 swap, 3 none |
| cfg_wdata_i | input | 16 | Write data |
| cfg_en_o | output | 16 | Enable register readback |
| cfg_dest_o | output | 2 | Destination field readback |
| cfg_swap_o | output | 1 | Swap bit readback |
| addr_i | input | 32 | Processor cycle address |
| tgt_o | output | 2 | Target: 00 none, 01 firmware, 10 PCI |
| addr_o | output | 32 | Address forwarded to the firmware device |

## Verification
The bench builds the decoder with EN_RST_VAL = 16'h5005 and DEST_RST_VAL = 2'b00. With these values, the enables loaded at reset already mix on and off windows in both the lower group (bits 0 and 2 on, bit 1 off) and the upper group (bits 12 and 14 on, bit 13 off). The platform-reset reload can therefore be seen in the decode as well as in the readback. Because the destination reset value is a firmware route and not the PCI code, the switch to PCI is made by a register write and then checked separately.

// File: rtl/bootwin_pkg.sv
package bootwin_pkg;
  localparam int ADDR_W   = 32;
  localparam int EN_W     = 16;
  localparam int WIN_N    = 8;
  localparam int LOW_N    = 4;
  localparam int SWAP_BIT = 16;
  localparam int UPPER_EN_BASE = 12;
  localparam logic [7:0] FW_TOP_BYTE = 8'hFF;
  localparam logic [1:0] DEST_TO_PCI = 2'b10;

  typedef enum logic [1:0] {
    TGT_NONE = 2'b00,
    TGT_FWH  = 2'b01,
    TGT_PCI  = 2'b10
  } tgt_e;

  typedef enum logic [1:0] {
    SEL_EN   = 2'd0,
    SEL_DEST = 2'd1,
    SEL_SWAP = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  function automatic int win_en_bit(input int w);
    if (w < LOW_N) return w;
    return UPPER_EN_BASE + (w - LOW_N);
  endfunction
endpackage

// File: rtl/bootwin_regs.sv
module bootwin_regs
  import bootwin_pkg::*;
#(
  parameter logic [EN_W-1:0] EN_RST_VAL   = 16'h700F,
  parameter logic [1:0]      DEST_RST_VAL = 2'b00
) (
  input  logic            clk,
  input  logic            rst_batt_n,
  input  logic            rst_plat_n,
  input  logic            wr_i,
  input  logic [1:0]      sel_i,
  input  logic [EN_W-1:0] wdata_i,
  output logic [EN_W-1:0] en_q,
  output logic [1:0]      dest_q,
  output logic            swap_q
);
  logic rst_all_n;
  logic wr_en, wr_dest, wr_swap;

  assign rst_all_n = rst_batt_n & rst_plat_n;
  assign wr_en     = wr_i && (sel_i == SEL_EN);
  assign wr_dest   = wr_i && (sel_i == SEL_DEST);
  assign wr_swap   = wr_i && (sel_i == SEL_SWAP) && rst_plat_n;

  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n) begin
      en_q   <= EN_RST_VAL;
      dest_q <= DEST_RST_VAL;
    end else begin
      if (wr_en)   en_q   <= wdata_i;
      if (wr_dest) dest_q <= wdata_i[1:0];
    end
  end

  // Battery domain only: survives a platform reset.
  always_ff @(posedge clk or negedge rst_batt_n) begin
    if (!rst_batt_n) swap_q <= 1'b0;
    else if (wr_swap) swap_q <= wdata_i[0];
  end
endmodule

// File: rtl/bootwin_match.sv
module bootwin_match
  import bootwin_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output logic [WIN_N-1:0]  hit_o
);
  logic top_ok;
  assign top_ok = (addr_i[31:24] == FW_TOP_BYTE);

  for (genvar w = 0; w < WIN_N; w++) begin : g_win
    if (w < LOW_N) begin : g_low
      // 1 MB windows, bit 22 ignored (alias pair)
      localparam logic [1:0] IDX = 2'(w);
      assign hit_o[w] = top_ok && !addr_i[23] && (addr_i[21:20] == IDX);
    end else begin : g_up
      // 512 KB windows, bit 22 ignored (alias pair)
      localparam logic [1:0] IDX = 2'(w - LOW_N);
      assign hit_o[w] = top_ok && addr_i[23] && addr_i[21] &&
                        (addr_i[20:19] == IDX);
    end
  end
endmodule

// File: rtl/bootwin_route.sv
module bootwin_route
  import bootwin_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIN_N-1:0]  hit_i,
  input  logic [EN_W-1:0]   en_i,
  input  logic [1:0]        dest_i,
  input  logic              swap_i,
  output tgt_e              tgt_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [WIN_N-1:0] win_on;
  logic any_hit, gated_hit, to_pci;

  for (genvar w = 0; w < WIN_N; w++) begin : g_mask
    if (w == WIN_N - 1) begin : g_always
      assign win_on[w] = 1'b1;
    end else begin : g_enabled
      assign win_on[w] = en_i[win_en_bit(w)];
    end
  end

  assign any_hit   = |hit_i;
  assign gated_hit = |(hit_i & win_on);
  assign to_pci    = (dest_i == DEST_TO_PCI);

  always_comb begin
    if (to_pci)         tgt_o = any_hit ? TGT_PCI : TGT_NONE;
    else if (gated_hit) tgt_o = TGT_FWH;
    else                tgt_o = TGT_NONE;
  end

  always_comb begin
    addr_o = addr_i;
    if (swap_i && (tgt_o == TGT_FWH)) addr_o[SWAP_BIT] = ~addr_i[SWAP_BIT];
  end
endmodule

// File: rtl/bootwin_decoder.sv
module bootwin_decoder
  import bootwin_pkg::*;
#(
  parameter logic [15:0] EN_RST_VAL   = 16'h700F,
  parameter logic [1:0]  DEST_RST_VAL = 2'b00
) (
  input  logic        clk,
  input  logic        rst_batt_n,
  input  logic        rst_plat_n,
  input  logic        cfg_wr_i,
  input  logic [1:0]  cfg_sel_i,
  input  logic [15:0] cfg_wdata_i,
  output logic [15:0] cfg_en_o,
  output logic [1:0]  cfg_dest_o,
  output logic        cfg_swap_o,
  input  logic [31:0] addr_i,
  output logic [1:0]  tgt_o,
  output logic [31:0] addr_o
);
  logic [WIN_N-1:0] hit;
  tgt_e             tgt;

  bootwin_regs #(.EN_RST_VAL(EN_RST_VAL), .DEST_RST_VAL(DEST_RST_VAL)) regs_i (
    .clk(clk), .rst_batt_n(rst_batt_n), .rst_plat_n(rst_plat_n),
    .wr_i(cfg_wr_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .en_q(cfg_en_o), .dest_q(cfg_dest_o), .swap_q(cfg_swap_o)
  );

  bootwin_match match_i (.addr_i(addr_i), .hit_o(hit));

  bootwin_route route_i (
    .addr_i(addr_i), .hit_i(hit), .en_i(cfg_en_o), .dest_i(cfg_dest_o),
    .swap_i(cfg_swap_o), .tgt_o(tgt), .addr_o(addr_o)
  );

  assign tgt_o = tgt;
endmodule

// File: rtl/bootwin_decoder_chk.sv
module bootwin_decoder_chk (
  input logic        clk,
  input logic        rst_batt_n,
  input logic        rst_plat_n,
  input logic        cfg_wr_i,
  input logic [1:0]  cfg_sel_i,
  input logic [15:0] cfg_wdata_i,
  input logic [15:0] cfg_en_o,
  input logic [1:0]  cfg_dest_o,
  input logic        cfg_swap_o,
  input logic [31:0] addr_i,
  input logic [1:0]  tgt_o,
  input logic [31:0] addr_o
);
  p_tgt_legal_r4: assert property (@(posedge clk) disable iff (!rst_batt_n || !rst_plat_n)
    tgt_o != 2'b11);

  p_none_pass_r4: assert property (@(posedge clk) disable iff (!rst_batt_n || !rst_plat_n)
    (tgt_o == 2'b00) |-> (addr_o == addr_i));

  p_pci_pass_r6: assert property (@(posedge clk) disable iff (!rst_batt_n || !rst_plat_n)
    (tgt_o == 2'b10) |-> (addr_o == addr_i));

  p_fwh_swap_r6: assert property (@(posedge clk) disable iff (!rst_batt_n || !rst_plat_n)
    (tgt_o == 2'b01) |-> ((addr_o[16] == (addr_i[16] ^ cfg_swap_o)) &&
                          (addr_o[31:17] == addr_i[31:17]) &&
                          (addr_o[15:0] == addr_i[15:0])));

  p_top_claim_r3: assert property (@(posedge clk) disable iff (!rst_batt_n || !rst_plat_n)
    ((addr_i[31:19] == 13'h1FFF) || (addr_i[31:19] == 13'h1FF7)) |-> (tgt_o != 2'b00));

  p_pci_mode_r5: assert property (@(posedge clk) disable iff (!rst_batt_n || !rst_plat_n)
    (cfg_dest_o == 2'b10) |-> (tgt_o != 2'b01));

  p_swap_hold_r7: assert property (@(posedge clk) disable iff (!rst_batt_n)
    $past(!(cfg_wr_i && cfg_sel_i == 2'd2)) |-> $stable(cfg_swap_o));

  p_en_write_r10: assert property (@(posedge clk) disable iff (!rst_batt_n || !rst_plat_n)
    (cfg_wr_i && cfg_sel_i == 2'd0) |=> (cfg_en_o == $past(cfg_wdata_i)));
endmodule

bind bootwin_decoder bootwin_decoder_chk chk_i (
  .clk(clk), .rst_batt_n(rst_batt_n), .rst_plat_n(rst_plat_n),
  .cfg_wr_i(cfg_wr_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
  .cfg_en_o(cfg_en_o), .cfg_dest_o(cfg_dest_o), .cfg_swap_o(cfg_swap_o),
  .addr_i(addr_i), .tgt_o(tgt_o), .addr_o(addr_o)
);

// File: tb/bootwin_decoder_tb.sv
module bootwin_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_batt_n = 1'b0;
  logic        rst_plat_n = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [1:0]  cfg_sel_i = 2'd0;
  logic [15:0] cfg_wdata_i = 16'h0;
  logic [15:0] cfg_en_o;
  logic [1:0]  cfg_dest_o;
  logic        cfg_swap_o;
  logic [31:0] addr_i = 32'h0;
  logic [1:0]  tgt_o;
  logic [31:0] addr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bootwin_decoder #(.EN_RST_VAL(16'h5005), .DEST_RST_VAL(2'b00)) dut_i (
    .clk(clk), .rst_batt_n(rst_batt_n), .rst_plat_n(rst_plat_n),
    .cfg_wr_i(cfg_wr_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_en_o(cfg_en_o), .cfg_dest_o(cfg_dest_o), .cfg_swap_o(cfg_swap_o),
    .addr_i(addr_i), .tgt_o(tgt_o), .addr_o(addr_o)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [15:0] en;
    logic [1:0]  dest;
    logic        swap;
    logic [31:0] addr;
    logic [1:0]  tgt;
    logic [31:0] xaddr;
  } vec_t;

  localparam int NV = 31;
  localparam logic [88:0] VEC [NV] = '{
    {4'd1, 16'h000F, 2'b00, 1'b0, 32'hFF40_1234, 2'd1, 32'hFF40_1234}, // R1
    {4'd1, 16'h000F, 2'b00, 1'b0, 32'hFF0A_5678, 2'd1, 32'hFF0A_5678}, // R1 alias
    {4'd1, 16'h0008, 2'b00, 1'b0, 32'hFF70_0000, 2'd1, 32'hFF70_0000}, // R1
    {4'd1, 16'h0008, 2'b00, 1'b0, 32'hFF3F_FFFF, 2'd1, 32'hFF3F_FFFF}, // R1
    {4'd1, 16'h0002, 2'b00, 1'b0, 32'hFF5C_0000, 2'd1, 32'hFF5C_0000}, // R1
    {4'd4, 16'h0008, 2'b00, 1'b0, 32'hFF60_0000, 2'd0, 32'hFF60_0000}, // R4
    {4'd2, 16'h1000, 2'b00, 1'b0, 32'hFFE0_0010, 2'd1, 32'hFFE0_0010}, // R2
    {4'd2, 16'h1000, 2'b00, 1'b0, 32'hFFA7_FFFF, 2'd1, 32'hFFA7_FFFF}, // R2
    {4'd2, 16'h2000, 2'b00, 1'b0, 32'hFFAC_0000, 2'd1, 32'hFFAC_0000}, // R2
    {4'd2, 16'h4000, 2'b00, 1'b0, 32'hFFF4_0000, 2'd1, 32'hFFF4_0000}, // R2
    {4'd2, 16'h4000, 2'b00, 1'b0, 32'hFFB0_0004, 2'd1, 32'hFFB0_0004}, // R2
    {4'd4, 16'h4000, 2'b00, 1'b0, 32'hFFE8_0000, 2'd0, 32'hFFE8_0000}, // R4
    {4'd3, 16'h0000, 2'b00, 1'b0, 32'hFFFF_FFF0, 2'd1, 32'hFFFF_FFF0}, // R3
    {4'd3, 16'h0000, 2'b00, 1'b0, 32'hFFB8_0000, 2'd1, 32'hFFB8_0000}, // R3
    {4'd4, 16'h0000, 2'b00, 1'b0, 32'hFFC0_0000, 2'd0, 32'hFFC0_0000}, // R4
    {4'd4, 16'hFFFF, 2'b00, 1'b0, 32'hFF80_0000, 2'd0, 32'hFF80_0000}, // R4 gap
    {4'd4, 16'hFFFF, 2'b00, 1'b0, 32'hFE40_0000, 2'd0, 32'hFE40_0000}, // R4
    {4'd4, 16'hFFFF, 2'b00, 1'b0, 32'h0000_1000, 2'd0, 32'h0000_1000}, // R4
    {4'd5, 16'h0000, 2'b10, 1'b0, 32'hFF40_0000, 2'd2, 32'hFF40_0000}, // R5
    {4'd5, 16'h0000, 2'b10, 1'b1, 32'hFFFF_0000, 2'd2, 32'hFFFF_0000}, // R5
    {4'd5, 16'hFFFF, 2'b10, 1'b0, 32'hFFC0_0000, 2'd0, 32'hFFC0_0000}, // R5
    {4'd5, 16'h000F, 2'b01, 1'b0, 32'hFF40_0000, 2'd1, 32'hFF40_0000}, // R5
    {4'd5, 16'h000F, 2'b11, 1'b0, 32'hFF40_0000, 2'd1, 32'hFF40_0000}, // R5
    {4'd6, 16'h0000, 2'b00, 1'b1, 32'hFFFF_0000, 2'd1, 32'hFFFE_0000}, // R6
    {4'd6, 16'h0000, 2'b00, 1'b1, 32'hFFFE_1234, 2'd1, 32'hFFFF_1234}, // R6
    {4'd6, 16'h0000, 2'b00, 1'b1, 32'hFFB9_0000, 2'd1, 32'hFFB8_0000}, // R6
    {4'd6, 16'h0000, 2'b00, 1'b1, 32'hFF40_0000, 2'd0, 32'hFF40_0000}, // R6
    {4'd6, 16'h0001, 2'b00, 1'b1, 32'hFF41_0000, 2'd1, 32'hFF40_0000}, // R6
    {4'd9, 16'h8FF0, 2'b00, 1'b0, 32'hFF40_0000, 2'd0, 32'hFF40_0000}, // R9
    {4'd9, 16'h8FF0, 2'b00, 1'b0, 32'hFFE0_0000, 2'd0, 32'hFFE0_0000}, // R9
    {4'd9, 16'h8FF0, 2'b00, 1'b1, 32'hFFE1_0000, 2'd0, 32'hFFE1_0000}  // R9
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [15:0] data);
    cfg_wr_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = data;
    @(posedge clk); @(negedge clk);
    cfg_wr_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_batt_n = 1'b1; rst_plat_n = 1'b1;
    #1;
    // R8 reset values
    check("R8 en reset", 32'(cfg_en_o), 32'h5005);
    check("R8 dest reset", 32'(cfg_dest_o), 32'h0);
    check("R8 swap reset", 32'(cfg_swap_o), 32'h0);
    addr_i = 32'hFF60_0000; #1;
    check("R8 bit2 on at reset", 32'(tgt_o), 32'd1);
    addr_i = 32'hFF50_0000; #1;
    check("R8 bit1 off at reset", 32'(tgt_o), 32'd0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      cfg_write(2'd0, v.en);
      cfg_write(2'd1, {14'd0, v.dest});
      cfg_write(2'd2, {15'd0, v.swap});
      addr_i = v.addr; #1;
      check($sformatf("R%0d vec%0d tgt", v.req, i), 32'(tgt_o), 32'(v.tgt));
      check($sformatf("R%0d vec%0d addr", v.req, i), addr_o, v.xaddr);
      @(negedge clk);
    end

    // R9 readback of unassigned bits
    cfg_write(2'd0, 16'h8FF0); #1;
    check("R9 readback", 32'(cfg_en_o), 32'h8FF0);
    @(negedge clk);

    // R10 select 3 ignored
    cfg_write(2'd1, 16'h0000);
    cfg_write(2'd2, 16'h0001);
    cfg_write(2'd3, 16'hFFFF); #1;
    check("R10 sel3 en", 32'(cfg_en_o), 32'h8FF0);
    check("R10 sel3 dest", 32'(cfg_dest_o), 32'h0);
    check("R10 sel3 swap", 32'(cfg_swap_o), 32'h1);
    @(negedge clk);

    // R10 / R11 write timing and combinational decode
    cfg_write(2'd0, 16'h0000);
    cfg_wr_i = 1'b1; cfg_sel_i = 2'd0; cfg_wdata_i = 16'h0001;
    addr_i = 32'hFF40_0000; #1;
    check("R10 before edge", 32'(tgt_o), 32'd0);
    @(posedge clk); @(negedge clk);
    cfg_wr_i = 1'b0; #1;
    check("R10 after edge", 32'(tgt_o), 32'd1);
    check("R11 swap addr", addr_o, 32'hFF41_0000);
    addr_i = 32'hFF50_0000; #1;
    check("R11 same-cycle change", 32'(tgt_o), 32'd0);
    @(negedge clk);

    // R7 platform reset keeps swap, reloads enables (R8)
    rst_plat_n = 1'b0; #1;
    check("R7 swap kept", 32'(cfg_swap_o), 32'h1);
    check("R8 en reload", 32'(cfg_en_o), 32'h5005);
    @(negedge clk);
    rst_plat_n = 1'b1; #1;
    addr_i = 32'hFFFF_0000; #1;
    check("R7 swap active after plat", addr_o, 32'hFFFE_0000);
    @(negedge clk);

    // R7 battery reset clears swap
    rst_batt_n = 1'b0; #1;
    check("R7 swap cleared", 32'(cfg_swap_o), 32'h0);
    @(negedge clk);
    rst_batt_n = 1'b1; #1;
    check("R7 addr unswapped", addr_o, 32'hFFFF_0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule